// File: doc/BRIEF.md
# Low-Cost Residue Check Unit

This block protects a binary adder with a separable residue code whose check base is A = 2^M − 1. Each operand travels next to a short check part; the data itself passes unchanged. The unit forms the check part of any word by cutting it into M-bit slices and folding them through a balanced tree of M-bit adders whose carry-out wraps around into the carry-in. No divider is used anywhere. A parameter picks the check form: either the residue itself or its inverse, A minus the residue. Because A is all ones, the inverse is the bitwise complement of the residue.

The residue code survives addition. The unit therefore takes the two operands, their incoming check parts, the adder's sum with its carry-out, and the sum's check part. It predicts the residue of the sum from the two operand check parts, and it recomputes every residue from the data. Any disagreement raises an error on a registered two-rail pair. A sticky flag also records it.

The unit forwards freshly generated check parts for both operands and for the sum. It also forwards a predicted check part for the sum, which downstream logic can attach to the result.

Top module: `rcu_residue_unit`

## Requirements
- R1: `a_chk_o` and `b_chk_o` carry the check form of `a_i mod A` and `b_i mod A`. A = 2^M − 1, and the all-ones value and zero both denote zero.
- R2: `sum_chk_o` carries the check form of (`sum_cout_i`·2^N + `sum_i`) mod A, so the carry-out counts as the next higher bit of the sum.
- R3: `pred_chk_o` carries the check form of (ra + rb) mod A. Here ra and rb are the residues encoded by `a_chk_i` and `b_chk_i`.
- R4: With the inverse form selected, every check part, incoming or outgoing, is A minus the residue, which is the bitwise complement of the residue.
- R5: When every check part agrees with its data and the sum residue equals the predicted residue, the rail pair after the next clock edge is 01 or 10.
- R6: Flipping any single bit of `sum_i`, or flipping `sum_cout_i`, gives an error rail pair after the next clock edge. An error pair has both rails equal (00 or 11).
- R7: Flipping any single bit of `a_chk_i`, `b_chk_i` or `sum_chk_i` gives an error rail pair after the next clock edge.
- R8: An incoming check part equal to all ones is accepted wherever zero would be correct, and the reverse also holds; no error is raised for it.
- R9: The upper rail toggles on every clock edge after reset, starting at 0 on the first edge. The lower rail is the complement of the upper rail on consistent cycles and equal to it on error cycles.
- R10: `err_sticky_o` rises one edge after an error cycle and stays high through later consistent cycles until reset.
- R11: A synchronous active-high reset sets the rail pair to 10 and clears `err_sticky_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a_i | input | N | First operand |
| b_i | input | N | Second operand |
| a_chk_i | input | M | Incoming check part of `a_i` |
| b_chk_i | input | M | Incoming check part of `b_i` |
| sum_i | input | N | Sum produced by the checked adder |
| sum_cout_i | input | 1 | Carry-out of the checked adder |
| sum_chk_i | input | M | Incoming check part of the sum |
| a_chk_o | output | M | Check part generated from `a_i` |
| b_chk_o | output | M | Check part generated from `b_i` |
| sum_chk_o | output | M | Check part generated from the sum and carry |
| pred_chk_o | output | M | Sum check part predicted from the operand check parts |
| err_rail_o | output | 2 | Registered two-rail indication: 01/10 consistent, 00/11 error |
| err_sticky_o | output | 1 | Set by any error until reset |

## Verification
Two things happen in the same cycle: the predicted sum check part is forwarded, and a corrupted operand check part is flagged. The bench provokes this by flipping one bit of `a_chk_i` or `b_chk_i` while the data stays correct. During that cycle it checks that `pred_chk_o` follows the corrupted value, and that `a_chk_o` and `b_chk_o` still follow the data. After the next edge it expects the error pair. Both check forms run side by side on the same stimulus, and the all-ones alias for zero is exercised on operand and sum check parts.

// File: rtl/rcu_pkg.sv
package rcu_pkg;

    // Which form a check part takes on the wires
    typedef enum logic {
        FORM_RESIDUE = 1'b0,
        FORM_INVERSE = 1'b1
    } chk_form_e;

    // Individual mismatch sources feeding the error rail
    typedef struct packed {
        logic add_bad;   // sum residue differs from prediction
        logic sum_bad;   // sum check part differs from sum data
        logic b_bad;     // operand b check part differs from data
        logic a_bad;     // operand a check part differs from data
    } err_cause_t;

    localparam logic [1:0] RAIL_RESET = 2'b10;

    // Build a rail pair from the phase bit and the error condition
    function automatic logic [1:0] rail_pair(input logic upper, input logic bad);
        return bad ? {upper, upper} : {upper, ~upper};
    endfunction

endpackage

// File: rtl/rcu_eac_adder.sv
module rcu_eac_adder #(
    parameter int M = 4
) (
    input  logic [M-1:0] x_i,
    input  logic [M-1:0] y_i,
    output logic [M-1:0] s_o
);
    localparam int WIDE = M + 1;

    logic [WIDE-1:0] raw;
    logic [M-1:0]    wrap;

    assign raw  = {1'b0, x_i} + {1'b0, y_i};
    // Carry-out fed back as carry-in; a second carry cannot occur
    assign wrap = M'(raw[M]);
    assign s_o  = raw[M-1:0] + wrap;

endmodule

// File: rtl/rcu_residue_tree.sv
module rcu_residue_tree #(
    parameter int M = 4,
    parameter int W = 16
) (
    input  logic [W-1:0] data_i,
    output logic [M-1:0] res_o
);
    localparam int SLICES = (W + M - 1) / M;
    localparam int LEVELS = (SLICES > 1) ? $clog2(SLICES) : 0;
    localparam int LEAVES = 1 << LEVELS;
    localparam int NODES  = 2 * LEAVES - 1;
    localparam int PW     = LEAVES * M;

    logic [PW-1:0] padded;
    logic [M-1:0]  node [NODES];

    assign padded = PW'(data_i);

    // Leaves: M-bit slices of the zero-extended word
    for (genvar k = 0; k < LEAVES; k++) begin : g_leaf
        assign node[LEAVES - 1 + k] = padded[k*M +: M];
    end

    // Inner nodes: end-around-carry adders, heap ordered
    for (genvar i = 0; i < LEAVES - 1; i++) begin : g_inner
        rcu_eac_adder #(.M(M)) u_add (
            .x_i (node[2*i + 1]),
            .y_i (node[2*i + 2]),
            .s_o (node[i])
        );
    end

    assign res_o = node[0];

endmodule

// File: rtl/rcu_form_conv.sv
module rcu_form_conv #(
    parameter int               M    = 4,
    parameter rcu_pkg::chk_form_e FORM = rcu_pkg::FORM_RESIDUE
) (
    input  logic [M-1:0] in_i,
    output logic [M-1:0] out_o
);
    // A - r equals ~r for A = all ones; the mapping is its own inverse
    if (FORM == rcu_pkg::FORM_INVERSE) begin : g_inv
        assign out_o = ~in_i;
    end else begin : g_plain
        assign out_o = in_i;
    end

endmodule

// File: rtl/rcu_mod_eq.sv
module rcu_mod_eq #(
    parameter int M = 4
) (
    input  logic [M-1:0] x_i,
    input  logic [M-1:0] y_i,
    output logic         eq_o
);
    logic [M-1:0] xn;
    logic [M-1:0] yn;

    // All ones and zero both stand for zero modulo 2^M - 1
    assign xn   = (x_i == '1) ? '0 : x_i;
    assign yn   = (y_i == '1) ? '0 : y_i;
    assign eq_o = (xn == yn);

endmodule

// File: rtl/rcu_rail_reg.sv
module rcu_rail_reg (
    input  logic       clk,
    input  logic       rst,
    input  logic       err_i,
    output logic [1:0] rail_o,
    output logic       sticky_o
);
    import rcu_pkg::*;

    logic       phase_q;
    logic [1:0] rail_q;
    logic       sticky_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= 1'b0;
            rail_q   <= RAIL_RESET;
            sticky_q <= 1'b0;
        end else begin
            phase_q  <= ~phase_q;
            rail_q   <= rail_pair(phase_q, err_i);
            sticky_q <= sticky_q | err_i;
        end
    end

    assign rail_o   = rail_q;
    assign sticky_o = sticky_q;

    AST_ERR_PAIR: assert property (@(posedge clk) disable iff (rst)
        err_i |=> (rail_q[1] == rail_q[0])); // R6
    AST_OK_PAIR: assert property (@(posedge clk) disable iff (rst)
        !err_i |=> (rail_q[1] != rail_q[0])); // R5
    AST_RAIL_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (!err_i && (rail_q[1] != rail_q[0])) |=> (rail_q[1] != $past(rail_q[1]))); // R9
    AST_STICKY_SET: assert property (@(posedge clk) disable iff (rst)
        err_i |=> sticky_q); // R10
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
        sticky_q |=> sticky_q); // R10

endmodule

// File: rtl/rcu_residue_unit.sv
module rcu_residue_unit #(
    parameter int                 N    = 16,
    parameter int                 M    = 4,
    parameter rcu_pkg::chk_form_e FORM = rcu_pkg::FORM_RESIDUE
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    input  logic [M-1:0] a_chk_i,
    input  logic [M-1:0] b_chk_i,
    input  logic [N-1:0] sum_i,
    input  logic         sum_cout_i,
    input  logic [M-1:0] sum_chk_i,
    output logic [M-1:0] a_chk_o,
    output logic [M-1:0] b_chk_o,
    output logic [M-1:0] sum_chk_o,
    output logic [M-1:0] pred_chk_o,
    output logic [1:0]   err_rail_o,
    output logic         err_sticky_o
);
    import rcu_pkg::*;

    localparam int SW = N + 1;

    logic [SW-1:0] sum_full;
    logic [M-1:0]  res_a, res_b, res_s;
    logic [M-1:0]  in_a, in_b, in_s;
    logic [M-1:0]  res_pred;
    logic          eq_a, eq_b, eq_s, eq_add;
    err_cause_t    cause;
    logic          err_now;

    assign sum_full = {sum_cout_i, sum_i};

    // Residues generated from the data words
    rcu_residue_tree #(.M(M), .W(N))  u_tree_a (.data_i(a_i),      .res_o(res_a));
    rcu_residue_tree #(.M(M), .W(N))  u_tree_b (.data_i(b_i),      .res_o(res_b));
    rcu_residue_tree #(.M(M), .W(SW)) u_tree_s (.data_i(sum_full), .res_o(res_s));

    // Incoming check parts back to residue form
    rcu_form_conv #(.M(M), .FORM(FORM)) u_in_a (.in_i(a_chk_i),   .out_o(in_a));
    rcu_form_conv #(.M(M), .FORM(FORM)) u_in_b (.in_i(b_chk_i),   .out_o(in_b));
    rcu_form_conv #(.M(M), .FORM(FORM)) u_in_s (.in_i(sum_chk_i), .out_o(in_s));

    // Sum residue predicted from the operand check parts
    rcu_eac_adder #(.M(M)) u_pred (.x_i(in_a), .y_i(in_b), .s_o(res_pred));

    // Outgoing check parts
    rcu_form_conv #(.M(M), .FORM(FORM)) u_out_a (.in_i(res_a),    .out_o(a_chk_o));
    rcu_form_conv #(.M(M), .FORM(FORM)) u_out_b (.in_i(res_b),    .out_o(b_chk_o));
    rcu_form_conv #(.M(M), .FORM(FORM)) u_out_s (.in_i(res_s),    .out_o(sum_chk_o));
    rcu_form_conv #(.M(M), .FORM(FORM)) u_out_p (.in_i(res_pred), .out_o(pred_chk_o));

    // Comparisons modulo 2^M - 1
    rcu_mod_eq #(.M(M)) u_eq_a   (.x_i(res_a), .y_i(in_a),     .eq_o(eq_a));
    rcu_mod_eq #(.M(M)) u_eq_b   (.x_i(res_b), .y_i(in_b),     .eq_o(eq_b));
    rcu_mod_eq #(.M(M)) u_eq_s   (.x_i(res_s), .y_i(in_s),     .eq_o(eq_s));
    rcu_mod_eq #(.M(M)) u_eq_add (.x_i(res_s), .y_i(res_pred), .eq_o(eq_add));

    always_comb begin
        cause.a_bad   = ~eq_a;
        cause.b_bad   = ~eq_b;
        cause.sum_bad = ~eq_s;
        cause.add_bad = ~eq_add;
    end

    assign err_now = |cause;

    rcu_rail_reg u_rail (
        .clk      (clk),
        .rst      (rst),
        .err_i    (err_now),
        .rail_o   (err_rail_o),
        .sticky_o (err_sticky_o)
    );

    AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (rst)
        (a_i == '0) |-> (res_a == '0)); // R1
    AST_BAD_CHK_A: assert property (@(posedge clk) disable iff (rst)
        cause.a_bad |=> (err_rail_o[1] == err_rail_o[0])); // R7

endmodule

// File: tb/rcu_residue_unit_tb.sv
module rcu_residue_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N = 16;
    localparam int M = 4;
    localparam int A = (1 << M) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] a_i = '0, b_i = '0, sum_i = '0;
    logic         cout_i = 1'b0;
    logic [M-1:0] ac_p = '0, bc_p = '0, sc_p = '0;
    logic [M-1:0] ac_n = '1, bc_n = '1, sc_n = '1;

    logic [M-1:0] p_a, p_b, p_s, p_p, n_a, n_b, n_s, n_p;
    logic [1:0]   p_rail, n_rail;
    logic         p_stk, n_stk;

    int checks = 0;
    int fails  = 0;
    int edges  = 0;
    bit sticky_exp = 1'b0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) edges <= rst ? 0 : edges + 1;

    rcu_residue_unit #(.N(N), .M(M), .FORM(rcu_pkg::FORM_RESIDUE)) u_dut (
        .clk(clk), .rst(rst), .a_i(a_i), .b_i(b_i),
        .a_chk_i(ac_p), .b_chk_i(bc_p), .sum_i(sum_i), .sum_cout_i(cout_i),
        .sum_chk_i(sc_p), .a_chk_o(p_a), .b_chk_o(p_b), .sum_chk_o(p_s),
        .pred_chk_o(p_p), .err_rail_o(p_rail), .err_sticky_o(p_stk));

    rcu_residue_unit #(.N(N), .M(M), .FORM(rcu_pkg::FORM_INVERSE)) u_dut_inv (
        .clk(clk), .rst(rst), .a_i(a_i), .b_i(b_i),
        .a_chk_i(ac_n), .b_chk_i(bc_n), .sum_i(sum_i), .sum_cout_i(cout_i),
        .sum_chk_i(sc_n), .a_chk_o(n_a), .b_chk_o(n_b), .sum_chk_o(n_s),
        .pred_chk_o(n_p), .err_rail_o(n_rail), .err_sticky_o(n_stk));

    function automatic int nrm(input int v);
        return (v == A) ? 0 : v;
    endfunction

    function automatic int fwd(input int r, input bit inv);
        return inv ? (A - r) : r;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic cmp_mod(input string tag, input string what, input int act, input int exp);
        chk(nrm(act) == nrm(exp), tag, what, act, exp);
    endtask

    // Set a consistent vector for both forms
    task automatic put_good(input logic [N-1:0] a, input logic [N-1:0] b);
        logic [N:0] s;
        s = {1'b0, a} + {1'b0, b};
        a_i = a; b_i = b; sum_i = s[N-1:0]; cout_i = s[N];
        ac_p = M'(fwd(int'(a) % A, 1'b0)); ac_n = M'(fwd(int'(a) % A, 1'b1));
        bc_p = M'(fwd(int'(b) % A, 1'b0)); bc_n = M'(fwd(int'(b) % A, 1'b1));
        sc_p = M'(fwd(int'(s) % A, 1'b0)); sc_n = M'(fwd(int'(s) % A, 1'b1));
    endtask

    // Combinational outputs against the driven inputs (R1..R4)
    task automatic check_gen();
        int rs, pp, pn;
        rs = int'({cout_i, sum_i}) % A;
        pp = (int'(ac_p) + int'(bc_p)) % A;
        pn = ((A - int'(ac_n)) + (A - int'(bc_n))) % A;
        #1;
        cmp_mod("R1", "a check plain", p_a, fwd(int'(a_i) % A, 1'b0));
        cmp_mod("R1", "b check plain", p_b, fwd(int'(b_i) % A, 1'b0));
        cmp_mod("R2", "sum check plain", p_s, fwd(rs, 1'b0));
        cmp_mod("R3", "pred check plain", p_p, fwd(pp, 1'b0));
        cmp_mod("R4", "a check inverse", n_a, fwd(int'(a_i) % A, 1'b1));
        cmp_mod("R4", "b check inverse", n_b, fwd(int'(b_i) % A, 1'b1));
        cmp_mod("R4", "sum check inverse", n_s, fwd(rs, 1'b1));
        cmp_mod("R4", "pred check inverse", n_p, fwd(pn, 1'b1));
    endtask

    // One clock edge, then rails and sticky flags
    task automatic run_cycle(input bit bad, input string tag);
        logic [1:0] exp;
        logic up;
        @(posedge clk);
        @(negedge clk);
        up = (edges % 2 == 0);
        exp = bad ? {up, up} : {up, ~up};
        if (bad) sticky_exp = 1'b1;
        chk(p_rail == exp, tag, "rail plain", p_rail, exp);
        chk(n_rail == exp, tag, "rail inverse", n_rail, exp);
        chk(p_stk == sticky_exp, tag, "sticky plain", p_stk, sticky_exp);
        chk(n_stk == sticky_exp, tag, "sticky inverse", n_stk, sticky_exp);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        sticky_exp = 1'b0;
        chk(p_rail == 2'b10, "R11", "reset rail plain", p_rail, 2);
        chk(n_rail == 2'b10, "R11", "reset rail inverse", n_rail, 2);
        chk(p_stk == 1'b0, "R11", "reset sticky plain", p_stk, 0);
        chk(n_stk == 1'b0, "R11", "reset sticky inverse", n_stk, 0);
        rst = 1'b0;
    endtask

    task automatic t_random();
        for (int i = 0; i < 200; i++) begin
            put_good(N'($urandom), N'($urandom));
            check_gen();
            run_cycle(1'b0, "R5");
        end
    endtask

    task automatic t_corners();
        put_good('0, '0);                check_gen(); run_cycle(1'b0, "R2");
        put_good('1, '1);                check_gen(); run_cycle(1'b0, "R2");
        put_good('1, N'(1));             check_gen(); run_cycle(1'b0, "R2");
        put_good(N'(A), N'(A));          check_gen(); run_cycle(1'b0, "R1");
    endtask

    task automatic t_alternate();
        for (int i = 0; i < 4; i++) begin
            put_good(N'(i * 4097 + 3), N'(i * 257));
            run_cycle(1'b0, "R9");
        end
    endtask

    task automatic t_zero_alias();
        // Operand with residue zero given its alternate zero encoding
        put_good(N'(A), N'(3 * A));
        ac_p = '1; bc_p = '0; ac_n = '0; bc_n = '1;
        sc_p = '1; sc_n = '0;
        check_gen();
        run_cycle(1'b0, "R8");
        put_good('0, '0);
        ac_p = '1; sc_p = '1; bc_n = '0; sc_n = '0;
        check_gen();
        run_cycle(1'b0, "R8");
    endtask

    task automatic t_sum_fault();
        for (int k = 0; k < N; k++) begin
            put_good(N'($urandom), N'($urandom));
            sum_i[k] = ~sum_i[k];
            check_gen();
            run_cycle(1'b1, "R6");
        end
        put_good(N'($urandom), N'($urandom));
        cout_i = ~cout_i;
        check_gen();
        run_cycle(1'b1, "R6");
    endtask

    task automatic t_chk_fault();
        for (int j = 0; j < M; j++) begin
            put_good(N'($urandom), N'($urandom));
            ac_p[j] = ~ac_p[j]; ac_n[j] = ~ac_n[j];
            check_gen();
            run_cycle(1'b1, "R7");
            put_good(N'($urandom), N'($urandom));
            bc_p[j] = ~bc_p[j]; bc_n[j] = ~bc_n[j];
            check_gen();
            run_cycle(1'b1, "R7");
            put_good(N'($urandom), N'($urandom));
            sc_p[j] = ~sc_p[j]; sc_n[j] = ~sc_n[j];
            check_gen();
            run_cycle(1'b1, "R7");
        end
    endtask

    task automatic t_sticky();
        for (int i = 0; i < 3; i++) begin
            put_good(N'($urandom), N'($urandom));
            run_cycle(1'b0, "R10");
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        put_good('0, '0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        t_reset();
        t_random();
        t_corners();
        t_alternate();
        t_zero_alias();
        t_sum_fault();
        t_chk_fault();
        t_sticky();
        t_reset();
        put_good(N'(77), N'(123));
        run_cycle(1'b0, "R11");
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule